// File: doc/BRIEF.md
# LCD Frame Buffer Address Generator

This block produces the word addresses that an LCD refresh engine reads from a video frame buffer in external memory. A 4-bit region select supplies the top nibble of every 32-bit address. The offset inside that region always starts at zero, so the buffer sits at the base of the selected region. Software sets the line length in pixels, the pixel depth and the total buffer size in bytes. The block then walks the buffer one 32-bit word at a time. Each fetch is offered with a request that the memory side acknowledges. After the last word of the buffer, the walk wraps back to offset zero.

Besides the addresses, the block marks line and frame boundaries with single-cycle strobes. A controller built around it uses these strobes to pace its line and frame timing. The control state machine has four states:
- IDLE: no request is issued.
- FETCH: a request is issued and held until it is acknowledged.
- LINE_END: the line strobe is given.
- FRAME_END: the line and frame strobes are given together.

The transitions are:
- IDLE to FETCH, when enabled.
- FETCH stays in FETCH on an acknowledged word that ends nothing.
- FETCH to LINE_END, on the acknowledged last word of a line.
- FETCH to FRAME_END, on the acknowledged last word of the buffer.
- LINE_END or FRAME_END back to FETCH.
- Any state to IDLE, whenever enable is low.

The region select is sampled on every clock and is not interlocked. It should only be changed while the block is disabled.

Top module: `lcdfb_addr_gen`

## Requirements
- R1: `fetch_addr[31:28]` equals the value `base_sel` had one clock earlier. This applies whether or not the block is enabled. Address bits [27:18] and [1:0] are always zero.
- R2: While `rst_n` is low, the region is 4'hC, so `fetch_addr` reads 32'hC000_0000. In the same condition `fetch_req`, `line_end` and `frame_end` are low.
- R3: In FETCH, `fetch_req` is high. While it is not acknowledged, the offset in `fetch_addr[17:0]` holds. Each acknowledged word advances the offset by 4 bytes, unless that word ends the buffer.
- R4: A line holds ceil(P x B / 32) words. P is the effective line length in pixels. B is the pixel depth given by `bpp_mode`: 0 means 1 bit, 1 means 2 bits, and 2 or 3 mean 4 bits.
- R5: The effective line length is `line_px` rounded down to a multiple of 16. It is then raised to 32 if smaller and lowered to 1024 if larger.
- R6: The buffer holds `buf_bytes`/4 words, rounded down. The count is at least 1 word. It is at most 32768 words when `buf_bytes` exceeds 131072. After the last word, the offset returns to 0.
- R7: `line_end` is high for exactly one cycle: the cycle after the acknowledge of a line's last word. `fetch_req` is low in that cycle. The line word count then restarts.
- R8: `frame_end` is high, together with `line_end`, for the one cycle after the acknowledge of the buffer's last word. In that cycle the offset is 0, and a new line starts.
- R9: When `enable` is seen low at a clock, `fetch_req` and both strobes go low from the next cycle, and the offset and line count return to zero. The first request after re-enabling comes one cycle after `enable` is seen high, at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the walk when high; holds IDLE at offset zero when low |
| base_sel | input | 4 | Region select that forms address bits [31:28] |
| line_px | input | 11 | Line length in pixels |
| bpp_mode | input | 2 | Pixel depth code: 0 = 1 bit, 1 = 2 bits, 2 or 3 = 4 bits |
| buf_bytes | input | 18 | Total frame buffer size in bytes |
| fetch_req | output | 1 | Word fetch request |
| fetch_ack | input | 1 | Acknowledge of the current request |
| fetch_addr | output | 32 | Byte address of the requested word |
| line_end | output | 1 | One-cycle strobe that closes a line |
| frame_end | output | 1 | One-cycle strobe that closes the buffer walk |

## Verification
The walk is swept over every pixel depth code, over line lengths of 32, 48, 80 and 1024 pixels, and over several small buffer sizes. Each combination runs under three acknowledge patterns: every cycle, every other cycle, and every third cycle. The sweep shows whether line strobes track the depth-scaled word count or only the pixel count, and whether the offset holds while a request is pending. Line lengths below 32, off the 16-pixel grid and above 1024 check the rounding and clamping. Buffer sizes of 0, 7, 10 and above the limit check the rounding, the one-word floor and the cap. One full-size buffer is walked to its wrap. Some runs change the region select on every cycle, and some drop enable part way through a frame; these show the one-cycle region latency and the restart at offset zero.

// File: rtl/lcdfb_pkg.sv
package lcdfb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_FETCH     = 2'd1,
        ST_LINE_END  = 2'd2,
        ST_FRAME_END = 2'd3
    } fb_state_e;

    typedef enum logic [1:0] {
        DEPTH_1  = 2'd0,
        DEPTH_2  = 2'd1,
        DEPTH_4  = 2'd2,
        DEPTH_4B = 2'd3
    } depth_e;

    // log2 of bits per pixel for a depth code (R4)
    function automatic logic [1:0] depth_shift(input depth_e d);
        unique case (d)
            DEPTH_1: depth_shift = 2'd0;
            DEPTH_2: depth_shift = 2'd1;
            default: depth_shift = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/lcdfb_cfg_decode.sv
module lcdfb_cfg_decode
    import lcdfb_pkg::*;
#(
    parameter int PX_W          = 11,
    parameter int MIN_PX        = 32,
    parameter int MAX_PX        = 1024,
    parameter int PX_STEP       = 16,
    parameter int WORD_BITS     = 32,
    parameter int BB_W          = 18,
    parameter int MAX_BUF_BYTES = 131072,
    parameter int LCNT_W        = 8,
    parameter int BCNT_W        = 16
) (
    input  logic [PX_W-1:0]   line_px,
    input  depth_e            depth,
    input  logic [BB_W-1:0]   buf_bytes,
    output logic [LCNT_W-1:0] line_words,
    output logic [BCNT_W-1:0] buf_words
);
    localparam int BITS_W    = PX_W + 3;
    localparam int WORD_LSB  = $clog2(WORD_BITS);
    localparam int BYTE_LSB  = $clog2(WORD_BITS / 8);
    localparam int MAX_WORDS = MAX_BUF_BYTES / (WORD_BITS / 8);

    localparam logic [PX_W-1:0] STEP_MASK = ~PX_W'(PX_STEP - 1);

    logic [PX_W-1:0]   px_grid;
    logic [PX_W-1:0]   px_eff;
    logic [BITS_W-1:0] line_bits;
    logic [BITS_W-1:0] words_full;
    logic [BB_W-1:0]   words_raw;

    // R5: round to the pixel grid, then clamp
    always_comb begin
        px_grid = line_px & STEP_MASK;
        if (px_grid < PX_W'(MIN_PX))
            px_eff = PX_W'(MIN_PX);
        else if (px_grid > PX_W'(MAX_PX))
            px_eff = PX_W'(MAX_PX);
        else
            px_eff = px_grid;
    end

    // R4: bits per line rounded up to whole words
    always_comb begin
        line_bits  = BITS_W'(px_eff) << depth_shift(depth);
        words_full = (line_bits + BITS_W'(WORD_BITS - 1)) >> WORD_LSB;
        line_words = LCNT_W'(words_full);
    end

    // R6: bytes to words, floor of one word, cap at the largest buffer
    always_comb begin
        words_raw = buf_bytes >> BYTE_LSB;
        if (buf_bytes > BB_W'(MAX_BUF_BYTES))
            buf_words = BCNT_W'(MAX_WORDS);
        else if (words_raw == '0)
            buf_words = BCNT_W'(1);
        else
            buf_words = BCNT_W'(words_raw);
    end

endmodule

// File: rtl/lcdfb_word_ctr.sv
module lcdfb_word_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] value,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;

    assign at_last = (cnt_q >= limit - CNT_W'(1));
    assign value   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (step)
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/lcdfb_line_ctr.sv
module lcdfb_line_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] limit,
    output logic             at_last
);
    logic [CNT_W-1:0] pos_q;

    assign at_last = (pos_q >= limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pos_q <= '0;
        else if (clear)
            pos_q <= '0;
        else if (step)
            pos_q <= at_last ? '0 : pos_q + CNT_W'(1);
    end

endmodule

// File: rtl/lcdfb_addr_gen.sv
module lcdfb_addr_gen
    import lcdfb_pkg::*;
#(
    parameter int              ADDR_W        = 32,
    parameter int              REGION_W      = 4,
    parameter logic [3:0]      RESET_REGION  = 4'hC,
    parameter int              PX_W          = 11,
    parameter int              MIN_PX        = 32,
    parameter int              MAX_PX        = 1024,
    parameter int              PX_STEP       = 16,
    parameter int              WORD_BITS     = 32,
    parameter int              MAX_BUF_BYTES = 131072,
    localparam int             BB_W          = $clog2(MAX_BUF_BYTES) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [REGION_W-1:0] base_sel,
    input  logic [PX_W-1:0]     line_px,
    input  logic [1:0]          bpp_mode,
    input  logic [BB_W-1:0]     buf_bytes,
    output logic                fetch_req,
    input  logic                fetch_ack,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic                line_end,
    output logic                frame_end
);
    localparam int BYTE_LSB  = $clog2(WORD_BITS / 8);
    localparam int MAX_WORDS = MAX_BUF_BYTES / (WORD_BITS / 8);
    localparam int BCNT_W    = $clog2(MAX_WORDS) + 1;
    localparam int LCNT_W    = $clog2(MAX_PX * 4 / WORD_BITS) + 1;
    localparam int OFF_W     = BCNT_W + BYTE_LSB;
    localparam int PAD_W     = ADDR_W - REGION_W - OFF_W;

    fb_state_e           state_q, state_d;
    logic [REGION_W-1:0] region_q;
    logic [LCNT_W-1:0]   line_words;
    logic [BCNT_W-1:0]   buf_words;
    logic [BCNT_W-1:0]   word_idx;
    logic                buf_last;
    logic                line_last;
    logic                fire;
    logic                line_clear;

    // region register: reset default, follows the select with no interlock (R1, R2)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            region_q <= REGION_W'(RESET_REGION);
        else
            region_q <= base_sel;
    end

    lcdfb_cfg_decode #(
        .PX_W          (PX_W),
        .MIN_PX        (MIN_PX),
        .MAX_PX        (MAX_PX),
        .PX_STEP       (PX_STEP),
        .WORD_BITS     (WORD_BITS),
        .BB_W          (BB_W),
        .MAX_BUF_BYTES (MAX_BUF_BYTES),
        .LCNT_W        (LCNT_W),
        .BCNT_W        (BCNT_W)
    ) i_decode (
        .line_px    (line_px),
        .depth      (depth_e'(bpp_mode)),
        .buf_bytes  (buf_bytes),
        .line_words (line_words),
        .buf_words  (buf_words)
    );

    assign fire       = (state_q == ST_FETCH) && fetch_ack && enable;
    assign line_clear = !enable || (fire && buf_last);

    lcdfb_word_ctr #(.CNT_W(BCNT_W)) i_word_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable),
        .step    (fire),
        .limit   (buf_words),
        .value   (word_idx),
        .at_last (buf_last)
    );

    lcdfb_line_ctr #(.CNT_W(LCNT_W)) i_line_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (line_clear),
        .step    (fire),
        .limit   (line_words),
        .at_last (line_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_FETCH;
                ST_FETCH: begin
                    if (fetch_ack) begin
                        if (buf_last)
                            state_d = ST_FRAME_END;
                        else if (line_last)
                            state_d = ST_LINE_END;
                        else
                            state_d = ST_FETCH;
                    end
                end
                ST_LINE_END:  state_d = ST_FETCH;
                ST_FRAME_END: state_d = ST_FETCH;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fetch_req = 1'b0;
        line_end  = 1'b0;
        frame_end = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_FETCH:     fetch_req = 1'b1;
            ST_LINE_END:  line_end  = 1'b1;
            ST_FRAME_END: begin
                line_end  = 1'b1;
                frame_end = 1'b1;
            end
            default:      ;
        endcase
    end

    assign fetch_addr = {region_q, {PAD_W{1'b0}}, word_idx, {BYTE_LSB{1'b0}}};

endmodule

// File: rtl/lcdfb_addr_gen_chk.sv
module lcdfb_addr_gen_chk #(
    parameter int ADDR_W   = 32,
    parameter int REGION_W = 4,
    parameter int OFF_W    = 18,
    parameter int BYTE_LSB = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic [REGION_W-1:0] base_sel,
    input logic                fetch_req,
    input logic                fetch_ack,
    input logic [ADDR_W-1:0]   fetch_addr,
    input logic                line_end,
    input logic                frame_end
);
    localparam logic [OFF_W-1:0] WORD_STEP = OFF_W'(1) << BYTE_LSB;

    a_r1_region_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> fetch_addr[ADDR_W-1:ADDR_W-REGION_W] == $past(base_sel));

    a_r1_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[BYTE_LSB-1:0] == '0 && fetch_addr[ADDR_W-REGION_W-1:OFF_W] == '0);

    a_r3_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack && enable |=> fetch_req && $stable(fetch_addr[OFF_W-1:0]));

    a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && fetch_ack && enable |=>
            frame_end || (fetch_addr[OFF_W-1:0] == $past(fetch_addr[OFF_W-1:0]) + WORD_STEP));

    a_r7_no_req_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> !fetch_req);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !line_end);

    a_r8_frame_with_line: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> line_end && fetch_addr[OFF_W-1:0] == '0);

    a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fetch_req && !line_end && fetch_addr[OFF_W-1:0] == '0);

endmodule

bind lcdfb_addr_gen lcdfb_addr_gen_chk #(
    .ADDR_W   (ADDR_W),
    .REGION_W (REGION_W),
    .OFF_W    (OFF_W),
    .BYTE_LSB (BYTE_LSB)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .base_sel   (base_sel),
    .fetch_req  (fetch_req),
    .fetch_ack  (fetch_ack),
    .fetch_addr (fetch_addr),
    .line_end   (line_end),
    .frame_end  (frame_end)
);

// File: tb/test_lcdfb_addr_gen.sv
module test_lcdfb_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [3:0]  base_sel = 4'h3;
    logic [10:0] line_px = 11'd32;
    logic [1:0]  bpp_mode = 2'd0;
    logic [17:0] buf_bytes = 18'd64;
    logic        fetch_req;
    logic        fetch_ack = 1'b0;
    logic [31:0] fetch_addr;
    logic        line_end;
    logic        frame_end;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the walk
    int m_phase = 0;   // 0 idle, 1 fetch, 2 line end, 3 frame end
    int m_idx = 0;
    int m_lw = 0;
    int m_region = 12;
    int m_lwords = 1;
    int m_bwords = 1;
    string tag_addr = "R3";
    string tag_line = "R7";

    always #10 clk = ~clk;

    lcdfb_addr_gen i_lcdfb_addr_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .base_sel   (base_sel),
        .line_px    (line_px),
        .bpp_mode   (bpp_mode),
        .buf_bytes  (buf_bytes),
        .fetch_req  (fetch_req),
        .fetch_ack  (fetch_ack),
        .fetch_addr (fetch_addr),
        .line_end   (line_end),
        .frame_end  (frame_end)
    );

    function automatic int exp_px(int px);
        int r = px - (px % 16);
        if (r < 32) r = 32;
        if (r > 1024) r = 1024;
        return r;
    endfunction

    function automatic int exp_lwords(int px, int mode);
        int b = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        return (exp_px(px) * b + 31) / 32;
    endfunction

    function automatic int exp_bwords(int bytes);
        if (bytes > 131072) return 32768;
        if (bytes / 4 == 0) return 1;
        return bytes / 4;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        m_region = int'(base_sel);
        if (!enable) begin
            m_phase = 0; m_idx = 0; m_lw = 0;
        end else if (m_phase == 1) begin
            if (fetch_ack) begin
                if (m_idx == m_bwords - 1) begin
                    m_phase = 3; m_idx = 0; m_lw = 0;
                end else if (m_lw == m_lwords - 1) begin
                    m_phase = 2; m_idx++; m_lw = 0;
                end else begin
                    m_idx++; m_lw++;
                end
            end
        end else begin
            m_phase = 1;
        end
    endtask

    task automatic check_outputs();
        check((m_phase == 0) ? "R9" : "R3", 32'(fetch_req), 32'(m_phase == 1));
        check("R1", 32'(fetch_addr[31:28]), 32'(m_region));
        check(tag_addr, {4'h0, fetch_addr[27:0]}, 32'(m_idx * 4));
        check(tag_line, 32'(line_end), 32'(m_phase >= 2));
        check("R8", 32'(frame_end), 32'(m_phase == 3));
    endtask

    task automatic tick();
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic run_cfg(int px, int bytes, int mode, int pat, int ncyc,
                           bit vary_region, int drop_at, string ta, string tl);
        enable = 1'b0;
        fetch_ack = 1'b0;
        tick();
        line_px   = 11'(px);
        buf_bytes = 18'(bytes);
        bpp_mode  = 2'(mode);
        m_lwords  = exp_lwords(px, mode);
        m_bwords  = exp_bwords(bytes);
        tag_addr  = ta;
        tag_line  = tl;
        tick();
        enable = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            case (pat)
                0:       fetch_ack = 1'b1;
                1:       fetch_ack = (c % 2) == 1;
                default: fetch_ack = (c % 3) == 2;
            endcase
            if (vary_region) base_sel = 4'((c * 5 + 3) & 15);
            enable = (c != drop_at);
            tick();
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stimulus
        // R2: reset state, with a non-default select on the input
        repeat (3) @(negedge clk);
        check("R2", fetch_addr, 32'hC000_0000);
        check("R2", 32'(fetch_req), 32'd0);
        check("R2", 32'({line_end, frame_end}), 32'd0);
        rst_n = 1'b1;
        tick();   // R1: region now follows the input
        check("R1", 32'(fetch_addr[31:28]), 32'h3);

        // R4, R3, R9, R1: sweep depth x line length x buffer size
        for (int mode = 0; mode < 4; mode++) begin
            for (int pi = 0; pi < 4; pi++) begin
                for (int bi = 0; bi < 3; bi++) begin
                    int px    = (pi == 0) ? 32 : (pi == 1) ? 48 : (pi == 2) ? 80 : 1024;
                    int bytes = (bi == 0) ? 4 : (bi == 1) ? 24 : 52;
                    int pat   = (mode + pi + bi) % 3;
                    bit vary  = ((mode + bi) % 2) == 1;
                    int drop  = (pi == 2) ? 40 : -1;
                    run_cfg(px, bytes, mode, pat, 120, vary, drop, "R3", "R4");
                end
            end
        end

        // R5: line length rounding and clamping
        run_cfg(16, 400, 2, 1, 150, 1'b0, -1, "R5", "R5");
        run_cfg(40, 400, 1, 0, 150, 1'b0, -1, "R5", "R5");
        run_cfg(2000, 400, 0, 2, 300, 1'b0, -1, "R5", "R5");
        run_cfg(1023, 400, 2, 0, 300, 1'b0, -1, "R5", "R5");

        // R6: buffer size rounding, floor and cap with full wrap
        run_cfg(32, 0, 0, 0, 20, 1'b0, -1, "R6", "R7");
        run_cfg(32, 7, 1, 1, 20, 1'b0, -1, "R6", "R7");
        run_cfg(64, 10, 0, 2, 30, 1'b1, -1, "R6", "R7");
        run_cfg(1024, 200000, 0, 0, 34000, 1'b0, -1, "R6", "R7");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule